// File: doc/BRIEF.md
# Conditional Skip Evaluator

This unit resolves the conditional-skip instructions of a 16-bit accumulator processor. Each cycle that the instruction strobe is high, it checks whether the instruction word belongs to the skip group. If it does, the unit picks one machine condition and applies the polarity the word asks for. It then reports whether the following word is to be stepped over. The conditions are the accumulator, the link bit and six device status lines.

The skip decision is combinational and valid in the same cycle as the strobe. The resulting program counter and an illegal-encoding flag are registered and appear one clock later. They hold their value until the next strobe. The PC input is the address that already follows the skip instruction, so a taken skip adds one and steps over exactly one word. Memory access and the devices themselves lie outside this unit.

Top module: `skip_eval`

## Requirements
- R1: A word belongs to the skip group only when bits 14..9 equal 000010 (binary), which is the octal pattern 002000 under the mask 077000. For a strobed word outside the group, skip_taken stays low, and one cycle later pc_next equals pc_in and illegal is low.
- R2: The low field is bits 8..0 and has exactly one bit set. The bit selects the tested condition:
  - bit 0: accumulator equal to zero
  - bit 1: accumulator sign bit (bit 15) clear
  - bit 2: link equal to zero
  - bit 3: disp_active high
  - bit 4: kbd_ready high
  - bit 5: rx_ready high
  - bit 6: tx_ready high
  - bit 7: sync_flag high
  - bit 8: rdr_ready high
- R3: Bit 15 of a group word inverts the tested condition. The zero tests become non-zero tests, the sign-clear test becomes a sign-set test, and each status test skips when its line is low.
- R4: When a skip is taken, pc_next equals pc_in + 1 modulo 2^PC_W on the clock edge that ends the strobe cycle, so 0xFFFF wraps to 0x0000.
- R5: When a strobed word does not take its skip, pc_next equals pc_in one cycle later.
- R6: A group word whose low field does not have exactly one bit set (none, or two or more) sets illegal one cycle later. Such a word never skips, and pc_next equals pc_in. A legal group word clears illegal.
- R7: skip_taken is combinational, valid in the strobe cycle, and low in every cycle without a strobe, whatever word is presented.
- R8: In a cycle without a strobe, pc_next and illegal keep their previous values.
- R9: While rst_n is low, pc_next is 0 and illegal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| pc_in | input | PC_W | Address following the instruction |
| ac | input | DATA_W | Accumulator value |
| link | input | 1 | Link bit |
| disp_active | input | 1 | Display processor running |
| kbd_ready | input | 1 | Keyboard has a character |
| rx_ready | input | 1 | Serial receiver has a character |
| tx_ready | input | 1 | Serial transmitter can accept |
| sync_flag | input | 1 | 40 Hz frame sync flag |
| rdr_ready | input | 1 | Tape reader has a character |
| pc_next | output | PC_W | Registered next program counter |
| skip_taken | output | 1 | Skip decision for the strobed word |
| illegal | output | 1 | Registered malformed-group-word flag |

## Verification
Assertions check the following relations on every cycle:
- the PC step or hold after each strobe, including the wrap at the top address;
- the hold of both registered outputs while the strobe is low;
- that skip_taken is silent without a strobe, that an illegal word never skips, and that non-group words never skip or flag;
- the accumulator-zero test in both polarities and the keyboard test.

The other seven condition selections, in both senses, are shown only by the bench. The bench drives each condition true and false in both polarities, with the unselected status lines at the opposite level. It also covers the specific malformed low fields and the reset values.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;

    // instruction word layout (fixed by the instruction format)
    localparam int INSTR_W   = 16;
    localparam int COND_N    = 9;
    localparam int GROUP_LSB = 9;
    localparam int GROUP_W   = 6;
    localparam int INV_BIT   = 15;
    localparam logic [GROUP_W-1:0] GROUP_CODE = 6'b000010;

    // condition slots, one per bit of the low field
    typedef enum int {
        CND_AC_ZERO  = 0,
        CND_AC_POS   = 1,
        CND_LINK_ZRO = 2,
        CND_DISP     = 3,
        CND_KBD      = 4,
        CND_RX       = 5,
        CND_TX       = 6,
        CND_SYNC     = 7,
        CND_RDR      = 8
    } cond_idx_e;

    // decoded view of one instruction word
    typedef struct packed {
        logic              in_group;
        logic              legal;
        logic              invert;
        logic [COND_N-1:0] sel;
    } dec_t;

endpackage

// File: rtl/skip_eval_decode.sv
module skip_eval_decode
    import skip_eval_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic [GROUP_W-1:0] grp_field;
    logic [COND_N-1:0]  low_field;
    logic               one_set;

    assign grp_field = instr[GROUP_LSB +: GROUP_W];
    assign low_field = instr[COND_N-1:0];

    // exactly one bit set in the selector field
    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < COND_N; i++) begin
            cnt = cnt + int'(low_field[i]);
        end
        one_set = (cnt == 1);
    end

    always_comb begin
        dec.in_group = (grp_field == GROUP_CODE);
        dec.legal    = dec.in_group && one_set;
        dec.invert   = instr[INV_BIT];
        dec.sel      = low_field;
    end

endmodule

// File: rtl/skip_eval_select.sv
module skip_eval_select #(
    parameter int N = 9
) (
    input  logic [N-1:0] cond,
    input  logic [N-1:0] sel,
    output logic         hit
);

    logic [N-1:0] term;

    // AND-OR selector; the decoder guarantees one-hot sel when it matters
    for (genvar g = 0; g < N; g++) begin : g_term
        assign term[g] = cond[g] & sel[g];
    end

    assign hit = |term;

endmodule

// File: rtl/skip_eval_incr.sv
module skip_eval_incr #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    // modulo 2^W step
    assign y = a + W'(1);

endmodule

// File: rtl/skip_eval.sv
module skip_eval
    import skip_eval_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [15:0]       instr,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] ac,
    input  logic              link,
    input  logic              disp_active,
    input  logic              kbd_ready,
    input  logic              rx_ready,
    input  logic              tx_ready,
    input  logic              sync_flag,
    input  logic              rdr_ready,
    output logic [PC_W-1:0]   pc_next,
    output logic              skip_taken,
    output logic              illegal
);

    localparam int SIGN_BIT = DATA_W - 1;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            illegal;
    } state_t;

    state_t            st_d, st_q;
    dec_t              dec;
    logic [COND_N-1:0] cond_vec;
    logic              cond_hit;
    logic              take;
    logic [PC_W-1:0]   pc_inc;

    skip_eval_decode i_decode (
        .instr (instr),
        .dec   (dec)
    );

    // gather condition lines in selector-bit order
    always_comb begin
        cond_vec               = '0;
        cond_vec[CND_AC_ZERO]  = (ac == '0);
        cond_vec[CND_AC_POS]   = ~ac[SIGN_BIT];
        cond_vec[CND_LINK_ZRO] = ~link;
        cond_vec[CND_DISP]     = disp_active;
        cond_vec[CND_KBD]      = kbd_ready;
        cond_vec[CND_RX]       = rx_ready;
        cond_vec[CND_TX]       = tx_ready;
        cond_vec[CND_SYNC]     = sync_flag;
        cond_vec[CND_RDR]      = rdr_ready;
    end

    skip_eval_select #(.N(COND_N)) i_select (
        .cond (cond_vec),
        .sel  (dec.sel),
        .hit  (cond_hit)
    );

    skip_eval_incr #(.W(PC_W)) i_incr (
        .a (pc_in),
        .y (pc_inc)
    );

    assign take = strobe && dec.legal && (cond_hit ^ dec.invert);

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.pc      = take ? pc_inc : pc_in;
            st_d.illegal = dec.in_group && !dec.legal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_next    = st_q.pc;
    assign illegal    = st_q.illegal;
    assign skip_taken = take;

endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic [15:0]       instr,
    input logic [PC_W-1:0]   pc_in,
    input logic [DATA_W-1:0] ac,
    input logic              kbd_ready,
    input logic [PC_W-1:0]   pc_next,
    input logic              skip_taken,
    input logic              illegal
);

    logic grp;
    assign grp = (instr[14:9] == 6'b000010);

    // R7
    no_skip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> !skip_taken);

    // R4
    step_on_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && skip_taken) |=> pc_next == $past(pc_in) + PC_W'(1));

    // R5
    hold_on_noskip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !skip_taken) |=> pc_next == $past(pc_in));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(pc_next) && $stable(illegal)));

    // R6
    illegal_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (!illegal || !$past(skip_taken)));

    // R1
    outside_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !grp) |-> !skip_taken);

    // R1
    outside_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !grp) |=> !illegal);

    // R2
    ac_zero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && instr == 16'o002001) |-> skip_taken == (ac == '0));

    // R3
    ac_nonzero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && instr == 16'o102001) |-> skip_taken == (ac != '0));

    // R2
    kbd_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && instr == 16'o002020) |-> skip_taken == kbd_ready);

endmodule

bind skip_eval skip_eval_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .instr      (instr),
    .pc_in      (pc_in),
    .ac         (ac),
    .kbd_ready  (kbd_ready),
    .pc_next    (pc_next),
    .skip_taken (skip_taken),
    .illegal    (illegal)
);

// File: tb/test_skip_eval.sv
module test_skip_eval;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe;
    logic [15:0] instr;
    logic [15:0] pc_in;
    logic [15:0] ac;
    logic        link;
    logic [5:0]  st; // disp, kbd, rx, tx, sync, rdr
    logic [15:0] pc_next;
    logic        skip_taken;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [15:0] pc;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] last_pc  = 16'h0000;
    logic        last_ill = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    skip_eval i_skip_eval (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .instr(instr),
        .pc_in(pc_in), .ac(ac), .link(link),
        .disp_active(st[0]), .kbd_ready(st[1]), .rx_ready(st[2]),
        .tx_ready(st[3]), .sync_flag(st[4]), .rdr_ready(st[5]),
        .pc_next(pc_next), .skip_taken(skip_taken), .illegal(illegal)
    );

    // reference decision from the requirements
    function automatic logic ref_take(input logic [15:0] w, input logic [15:0] a,
                                      input logic l, input logic [5:0] s);
        logic c;
        if (w[14:9] != 6'b000010) return 1'b0;
        case (w[8:0])
            9'o001: c = (a == 16'h0000);
            9'o002: c = !a[15];
            9'o004: c = !l;
            9'o010: c = s[0];
            9'o020: c = s[1];
            9'o040: c = s[2];
            9'o100: c = s[3];
            9'o200: c = s[4];
            9'o400: c = s[5];
            default: return 1'b0;
        endcase
        return c ^ w[15];
    endfunction

    function automatic logic ref_illegal(input logic [15:0] w);
        if (w[14:9] != 6'b000010) return 1'b0;
        return $countones(w[8:0]) != 1;
    endfunction

    task automatic check1(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [15:0] w, input logic [15:0] p,
                         input logic [15:0] a, input logic l, input logic [5:0] s);
        logic t;
        exp_t e;
        @(negedge clk);
        strobe = 1'b1; instr = w; pc_in = p; ac = a; link = l; st = s;
        t = ref_take(w, a, l, s);
        #1;
        check1({tag, " skip_taken (R7)"}, {15'd0, skip_taken}, {15'd0, t});
        e.pc  = t ? p + 16'd1 : p;
        e.ill = ref_illegal(w);
        e.tag = tag;
        last_pc  = e.pc;
        last_ill = e.ill;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        strobe = 1'b0;
        instr  = 16'o002001; ac = 16'h0000; // would skip if strobed
        #1;
        check1({tag, " R7 no strobe"}, {15'd0, skip_taken}, 16'd0);
        e.pc = last_pc; e.ill = last_ill; e.tag = {tag, " R8 hold"};
        sb.push_back(e);
    endtask

    // monitor: compare registered results after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check1({e.tag, " pc_next"}, pc_next, e.pc);
                check1({e.tag, " illegal"}, {15'd0, illegal}, {15'd0, e.ill});
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; strobe = 1'b0; instr = '0; pc_in = '0;
        ac = '0; link = 1'b0; st = '0;
        repeat (3) @(posedge clk);
        #2;
        // R9 reset values
        check1("R9 reset pc_next", pc_next, 16'h0000);
        check1("R9 reset illegal", {15'd0, illegal}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R3: every condition, both polarities, true and false
        for (int c = 0; c < 9; c++) begin
            for (int p = 0; p < 2; p++) begin
                for (int t = 0; t < 2; t++) begin
                    logic [15:0] w, a;
                    logic        l;
                    logic [5:0]  s;
                    w = 16'o002000 | (16'd1 << c);
                    if (p == 1) w[15] = 1'b1;
                    a = 16'h0123; l = 1'b1; s = 6'b000000;
                    case (c)
                        0: a = (t == 1) ? 16'h0000 : 16'h0123;
                        1: a = (t == 1) ? 16'h1234 : 16'h8001;
                        2: l = (t == 1) ? 1'b0 : 1'b1;
                        default: begin
                            s = (t == 1) ? 6'b000000 : 6'b111111;
                            s[c-3] = (t == 1);
                        end
                    endcase
                    apply((p == 1) ? "R3 inverted" : "R2 direct", w,
                          16'h0100 + 16'(c * 4 + p * 2 + t), a, l, s);
                end
            end
        end

        // R4 wrap at the top address
        apply("R4 wrap", 16'o002001, 16'hFFFF, 16'h0000, 1'b0, 6'b0);
        // R5 not taken at top address
        apply("R5 no wrap", 16'o002001, 16'hFFFF, 16'h0001, 1'b0, 6'b0);

        // R6 malformed group words
        apply("R6 empty field", 16'o002000, 16'h2000, 16'h0000, 1'b0, 6'h3F);
        idle("R6 hold illegal");
        apply("R6 two bits", 16'o002003, 16'h2001, 16'h0000, 1'b0, 6'h3F);
        apply("R6 all bits inv", 16'o102777, 16'h2002, 16'h5555, 1'b1, 6'h00);
        apply("R6 legal clears", 16'o002004, 16'h2003, 16'h0000, 1'b0, 6'h00);

        // R1 words outside the group
        apply("R1 microcode", 16'o000001, 16'h3000, 16'h0000, 1'b0, 6'h3F);
        apply("R1 other page", 16'o004001, 16'h3001, 16'h0000, 1'b0, 6'h3F);
        apply("R1 io word", 16'o001021, 16'h3002, 16'h0000, 1'b0, 6'h3F);
        apply("R1 bit15 only", 16'o100000, 16'h3003, 16'h0000, 1'b0, 6'h3F);

        // R7 / R8 idle cycles after a taken skip
        apply("R4 before idle", 16'o002020, 16'h4000, 16'h0000, 1'b0, 6'b000010);
        idle("R8 first");
        idle("R8 second");

        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule